// File: doc/BRIEF.md
# Register-Load Command Stream Parser

This block sits after a command fetch unit and takes 32-bit command words, one per valid/ready handshake. It decodes each header word: the client class in bits 31:29, the opcode in bits 28:23 for the memory-interface class, and a length field in bits 7:0. It turns immediate register-load commands into a stream of register write transactions on a simple write port. It consumes every other command without acting on it, either as a single word or by skipping its payload.

A register-load header carries opcode 0x22 and a length field of 2N-1 for N address/value pairs. Each address word is followed by its data word. The block enforces several rules on a load. The header must directly follow a no-op header. The pair count must lie within a parameterised limit, 126 by default. Each register address must be dword aligned. When a load breaks one of these rules, the block raises a one-cycle error flag and drops the affected writes. When header bit 19 is set, the block forms each address as a fixed engine base plus the offset masked to bits 12:2.

The write port is a single registered slot. While a write waits for the port, the input is stalled, so at most one write leaves the block per cycle.

Top module: `rlp_cmd_parser`

## Requirements
- R1: A header whose client field (bits 31:29) is not 0, 2 or 3 raises err_client for one cycle. Only that header word is consumed, and the next word is decoded as a header.
- R2: A client-0 header with opcode 0x00 (no-op) produces no write and no flag. A client-0 header with opcode 0x0A (end of batch) pulses batch_end.
- R3: A client-0 header with opcode 0x22 and an odd length field L = 2N-1 (bits 7:0) is followed by N address/data word pairs. The block issues one write per pair, in arrival order, with the address word first in each pair.
- R4: A register-load header is accepted only when the header consumed just before it was a no-op. Otherwise err_order pulses and the L+1 payload words are consumed without any write.
- R5: A register-load header whose length field is even, or exceeds 2*MAX_PAIRS-1, pulses err_length. Its L+1 payload words are consumed without any write. R4 and R5 may flag together.
- R6: When bit 19 of the register-load header is set, every write address is ENGINE_BASE + (address word AND 0x1FFC). When bit 19 is clear, the address word is used unchanged.
- R7: An address word with bits 1:0 nonzero pulses err_align, in either addressing mode. That pair's data word is consumed and no write is issued for it. The other pairs of the command still write.
- R8: Client-2 and client-3 headers, and client-0 headers with opcode 0x10 or above other than 0x22, are followed by L+1 payload words, which are skipped. Client-0 headers with opcodes below 0x10 are single words.
- R9: wr_valid, wr_addr and wr_data hold until wr_ready is seen. in_ready is low exactly while wr_valid is high and wr_ready is low.
- R10: Every flag pulses for exactly the one cycle after the word that caused it is accepted.
- R11: After reset, in_ready is high, wr_valid is low and every flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Command word can be taken |
| wr_ready | input | 1 | Write port accepts the current write |
| wr_valid | output | 1 | Register write pending |
| wr_addr | output | 32 | Register write address |
| wr_data | output | 32 | Register write value |
| err_client | output | 1 | Unknown client class seen |
| err_order | output | 1 | Register load not preceded by a no-op |
| err_length | output | 1 | Register load length malformed or over limit |
| err_align | output | 1 | Misaligned register address, pair dropped |
| batch_end | output | 1 | End-of-batch header seen |

## Verification
The bench targets the ways a parser loses word framing. A skip count off by one would make it decode a payload word as a header and produce phantom writes. A no-op flag cleared at the wrong time would accept a load behind a render header or behind a single-word opcode. Other targets are a load of exactly the pair limit against one just past it, and an even length field. It also covers the engine-relative mask applied to high offset bits, and a misaligned pair in the middle of a command, where a wrong design would either write it or drop its neighbours. Random backpressure on the write port exposes a design that overwrites a pending write or keeps accepting input while stalled.

// File: rtl/rlp_pkg.sv
package rlp_pkg;

  localparam int WORD_W  = 32;
  localparam int LEN_W   = 8;
  localparam int REL_BIT = 19;

  localparam logic [2:0] CLIENT_MI  = 3'd0;
  localparam logic [2:0] CLIENT_BLT = 3'd2;
  localparam logic [2:0] CLIENT_RND = 3'd3;

  localparam logic [5:0] OPC_NOOP     = 6'h00;
  localparam logic [5:0] OPC_END      = 6'h0A;
  localparam logic [5:0] OPC_LOAD     = 6'h22;
  localparam logic [5:0] OPC_LONG_MIN = 6'h10;

  // flag vector bit positions
  localparam int FL_CLIENT = 0;
  localparam int FL_ORDER  = 1;
  localparam int FL_LENGTH = 2;
  localparam int FL_ALIGN  = 3;
  localparam int FL_END    = 4;
  localparam int FL_W      = 5;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } pstate_e;

  typedef enum logic [2:0] {
    HK_NOOP,
    HK_END,
    HK_LOAD,
    HK_SKIP,
    HK_SINGLE,
    HK_BADCL
  } hkind_e;

  typedef struct packed {
    hkind_e           kind;
    logic             rel;
    logic             len_bad;
    logic [LEN_W-1:0] len;
  } hdr_info_t;

endpackage

// File: rtl/rlp_hdr_decode.sv
module rlp_hdr_decode
  import rlp_pkg::*;
#(
  parameter int MAX_PAIRS = 126
) (
  input  logic [WORD_W-1:0] word,
  output hdr_info_t         info
);

  localparam int MAX_LEN = 2 * MAX_PAIRS - 1;

  logic [2:0] client;
  logic [5:0] opc;

  always_comb begin
    client       = word[31:29];
    opc          = word[28:23];
    info.len     = word[LEN_W-1:0];
    info.rel     = word[REL_BIT];
    info.len_bad = ~word[0] | (int'(word[LEN_W-1:0]) > MAX_LEN);
    info.kind    = HK_BADCL;
    if (client == CLIENT_MI) begin
      if (opc == OPC_NOOP)          info.kind = HK_NOOP;
      else if (opc == OPC_END)      info.kind = HK_END;
      else if (opc == OPC_LOAD)     info.kind = HK_LOAD;
      else if (opc >= OPC_LONG_MIN) info.kind = HK_SKIP;
      else                          info.kind = HK_SINGLE;
    end else if (client == CLIENT_BLT || client == CLIENT_RND) begin
      info.kind = HK_SKIP;
    end
  end

endmodule

// File: rtl/rlp_addr_map.sv
module rlp_addr_map
  import rlp_pkg::*;
#(
  parameter logic [WORD_W-1:0] BASE   = 32'h0002_0000,
  parameter int                OFS_HI = 12
) (
  input  logic [WORD_W-1:0] raw,
  input  logic              rel,
  output logic [WORD_W-1:0] addr,
  output logic              misaligned
);

  localparam logic [WORD_W-1:0] OFS_MASK =
    ((WORD_W'(1) << (OFS_HI + 1)) - WORD_W'(1)) & ~WORD_W'(3);

  always_comb begin
    addr       = rel ? (BASE + (raw & OFS_MASK)) : raw;
    misaligned = |raw[1:0];
  end

endmodule

// File: rtl/rlp_wr_slot.sv
module rlp_wr_slot
  import rlp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              busy
);

  logic valid_q, valid_n;
  logic [WORD_W-1:0] addr_q, data_q;

  always_comb begin
    valid_n = load | (valid_q & ~wr_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      addr_q <= ld_addr;
      data_q <= ld_data;
    end
  end

  assign wr_valid = valid_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign busy     = valid_q & ~wr_ready;

endmodule

// File: rtl/rlp_cmd_parser.sv
module rlp_cmd_parser
  import rlp_pkg::*;
#(
  parameter int                MAX_PAIRS   = 126,
  parameter logic [WORD_W-1:0] ENGINE_BASE = 32'h0002_0000,
  parameter int                OFS_HI      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              err_client,
  output logic              err_order,
  output logic              err_length,
  output logic              err_align,
  output logic              batch_end
);

  localparam int CNT_W  = $clog2(MAX_PAIRS + 1);
  localparam int SKIP_W = LEN_W + 1;

  pstate_e           st_q, st_n;
  logic [CNT_W-1:0]  pairs_q, pairs_n;
  logic [SKIP_W-1:0] skip_q, skip_n;
  logic              rel_q, rel_n;
  logic              drop_q, drop_n;
  logic              noop_q, noop_n;
  logic [FL_W-1:0]   flag_q, flag_n;
  logic [WORD_W-1:0] addr_q;

  hdr_info_t         info;
  logic [WORD_W-1:0] mapped;
  logic              misal;
  logic              busy, accept, wr_load, addr_en;
  logic [SKIP_W-1:0] len_plus1;

  rlp_hdr_decode #(.MAX_PAIRS(MAX_PAIRS)) u_dec (
    .word (in_data),
    .info (info)
  );

  rlp_addr_map #(.BASE(ENGINE_BASE), .OFS_HI(OFS_HI)) u_map (
    .raw        (in_data),
    .rel        (rel_q),
    .addr       (mapped),
    .misaligned (misal)
  );

  rlp_wr_slot u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_load),
    .ld_addr  (addr_q),
    .ld_data  (in_data),
    .wr_ready (wr_ready),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .busy     (busy)
  );

  assign in_ready  = ~busy;
  assign accept    = in_valid & in_ready;
  assign len_plus1 = {1'b0, info.len} + SKIP_W'(1);

  // next-state logic
  always_comb begin
    st_n    = st_q;
    pairs_n = pairs_q;
    skip_n  = skip_q;
    rel_n   = rel_q;
    drop_n  = drop_q;
    noop_n  = noop_q;
    flag_n  = '0;
    wr_load = 1'b0;
    addr_en = 1'b0;
    if (accept) begin
      unique case (st_q)
        ST_HDR: begin
          noop_n = 1'b0;
          unique case (info.kind)
            HK_NOOP:   noop_n = 1'b1;
            HK_END:    flag_n[FL_END] = 1'b1;
            HK_SINGLE: ;
            HK_BADCL:  flag_n[FL_CLIENT] = 1'b1;
            HK_SKIP: begin
              skip_n = len_plus1;
              st_n   = ST_SKIP;
            end
            HK_LOAD: begin
              flag_n[FL_ORDER]  = ~noop_q;
              flag_n[FL_LENGTH] = info.len_bad;
              if (!noop_q || info.len_bad) begin
                skip_n = len_plus1;
                st_n   = ST_SKIP;
              end else begin
                pairs_n = CNT_W'(len_plus1 >> 1);
                rel_n   = info.rel;
                st_n    = ST_ADDR;
              end
            end
            default: flag_n[FL_CLIENT] = 1'b1;
          endcase
        end
        ST_ADDR: begin
          addr_en          = 1'b1;
          drop_n           = misal;
          flag_n[FL_ALIGN] = misal;
          st_n             = ST_DATA;
        end
        ST_DATA: begin
          wr_load = ~drop_q;
          pairs_n = pairs_q - CNT_W'(1);
          st_n    = (pairs_q == CNT_W'(1)) ? ST_HDR : ST_ADDR;
        end
        ST_SKIP: begin
          skip_n = skip_q - SKIP_W'(1);
          if (skip_q == SKIP_W'(1)) st_n = ST_HDR;
        end
        default: st_n = ST_HDR;
      endcase
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HDR;
      pairs_q <= '0;
      skip_q  <= '0;
      rel_q   <= 1'b0;
      drop_q  <= 1'b0;
      noop_q  <= 1'b0;
      flag_q  <= '0;
    end else begin
      st_q    <= st_n;
      pairs_q <= pairs_n;
      skip_q  <= skip_n;
      rel_q   <= rel_n;
      drop_q  <= drop_n;
      noop_q  <= noop_n;
      flag_q  <= flag_n;
    end
  end

  // address holding register, enabled on address words only
  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= mapped;
  end

  assign err_client = flag_q[FL_CLIENT];
  assign err_order  = flag_q[FL_ORDER];
  assign err_length = flag_q[FL_LENGTH];
  assign err_align  = flag_q[FL_ALIGN];
  assign batch_end  = flag_q[FL_END];

endmodule

// File: rtl/rlp_cmd_parser_chk.sv
module rlp_cmd_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        wr_ready,
  input logic        wr_valid,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        err_client,
  input logic        err_order,
  input logic        err_length,
  input logic        err_align,
  input logic        batch_end
);

  AST_STALL_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !in_ready); // R9

  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R9

  AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00)); // R7

  AST_FLAG_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_client || err_order || err_length || err_align || batch_end)
      |-> $past(in_valid && in_ready)); // R10

  AST_WRITE_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(in_valid && in_ready)); // R3

endmodule

bind rlp_cmd_parser rlp_cmd_parser_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .wr_ready   (wr_ready),
  .wr_valid   (wr_valid),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .err_client (err_client),
  .err_order  (err_order),
  .err_length (err_length),
  .err_align  (err_align),
  .batch_end  (batch_end)
);

// File: tb/sim_rlp_cmd_parser.sv
module sim_rlp_cmd_parser;

  localparam int          MAXP = 126;
  localparam logic [31:0] BASE = 32'h0002_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, in_ready, wr_ready, wr_valid;
  logic [31:0] in_data, wr_addr, wr_data;
  logic        err_client, err_order, err_length, err_align, batch_end;

  rlp_cmd_parser #(.MAX_PAIRS(MAXP), .ENGINE_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .err_client(err_client),
    .err_order(err_order), .err_length(err_length), .err_align(err_align),
    .batch_end(batch_end)
  );

  int n_cmp = 0, n_bad = 0;
  int wr_seen = 0, wr_exp = 0;
  bit mon_on = 1'b0;
  bit bp = 1'b0;
  logic [63:0] expq[$];
  logic [4:0]  exp_flags = '0;

  // reference model state
  int          m_st = 0, m_cnt = 0, m_skip = 0;
  bit          m_nop = 0, m_cs = 0, m_drop = 0;
  logic [31:0] m_addr = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic [31:0] w);
    int cl, op, ln;
    bit was, bad;
    cl = int'(w[31:29]); op = int'(w[28:23]); ln = int'(w[7:0]);
    case (m_st)
      0: begin
        if (cl == 0 && op == 0) m_nop = 1;
        else begin
          was = m_nop; m_nop = 0;
          if (cl == 0) begin
            if (op == 'h0A) exp_flags[4] = 1'b1;
            else if (op == 'h22) begin
              bad = (ln % 2 == 0) || (ln > 2 * MAXP - 1);
              if (!was) exp_flags[1] = 1'b1;
              if (bad)  exp_flags[2] = 1'b1;
              if (!was || bad) begin m_skip = ln + 1; m_st = 3; end
              else begin m_cnt = (ln + 1) / 2; m_cs = w[19]; m_st = 1; end
            end else if (op >= 'h10) begin m_skip = ln + 1; m_st = 3; end
          end else if (cl == 2 || cl == 3) begin m_skip = ln + 1; m_st = 3; end
          else exp_flags[0] = 1'b1;
        end
      end
      1: begin
        m_drop = (w[1:0] != 2'b00);
        if (m_drop) exp_flags[3] = 1'b1;
        m_addr = m_cs ? (BASE + (w & 32'h0000_1FFC)) : w;
        m_st = 2;
      end
      2: begin
        if (!m_drop) begin expq.push_back({m_addr, w}); wr_exp++; end
        m_cnt--;
        m_st = (m_cnt == 0) ? 0 : 1;
      end
      default: begin
        m_skip--;
        if (m_skip == 0) m_st = 0;
      end
    endcase
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (mon_on) begin
      chk("R9 in_ready", 32'(in_ready), 32'(!(expq.size() > 0 && !wr_ready)));
      chk("R9 wr_valid", 32'(wr_valid), 32'(expq.size() > 0));
      if (expq.size() > 0 && wr_valid) begin
        chk("R3 R6 wr_addr", wr_addr, expq[0][63:32]);
        chk("R3 wr_data", wr_data, expq[0][31:0]);
        if (wr_ready) begin void'(expq.pop_front()); wr_seen++; end
      end
      chk("R1 R10 err_client", 32'(err_client), 32'(exp_flags[0]));
      chk("R4 R10 err_order",  32'(err_order),  32'(exp_flags[1]));
      chk("R5 R10 err_length", 32'(err_length), 32'(exp_flags[2]));
      chk("R7 R10 err_align",  32'(err_align),  32'(exp_flags[3]));
      chk("R2 R10 batch_end",  32'(batch_end),  32'(exp_flags[4]));
      exp_flags = '0;
      if (in_valid && in_ready) model_step(in_data);
    end
  end

  // write-port backpressure driver
  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    wr_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_ready = bp ? lfsr[0] : 1'b1;
    end
  end

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1; in_data = w;
    forever begin @(negedge clk); if (in_ready) break; end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] mi(input logic [5:0] op, input logic [22:0] low);
    return {3'd0, op, low};
  endfunction

  function automatic logic [31:0] ld(input int len, input bit rel);
    return {3'd0, 6'h22, 23'd0} | (rel ? 32'h0008_0000 : 32'd0) | 32'(len);
  endfunction

  task automatic nop();
    send(mi(6'h00, 23'd0));
  endtask

  task automatic settle(input string tag);
    repeat (6) @(posedge clk);
    #1;
    chk({tag, " queue drained"}, 32'(expq.size()), 32'd0);
    chk({tag, " write count"}, 32'(wr_seen), 32'(wr_exp));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R11 in_ready", 32'(in_ready), 32'd1);
    chk("R11 wr_valid", 32'(wr_valid), 32'd0);
    chk("R11 flags", 32'({err_client, err_order, err_length, err_align, batch_end}), 32'd0);
    mon_on = 1'b1;
    @(posedge clk); #1;

    // R3: single pair, plain addressing
    nop(); send(ld(1, 0)); send(32'h0000_0100); send(32'hA5A5_0001);
    settle("R3");

    // R9: three pairs under random backpressure
    bp = 1'b1;
    nop(); send(ld(5, 0));
    send(32'h204); send(32'h11); send(32'h208); send(32'h22); send(32'hFFC); send(32'h33);
    settle("R9");

    // R4: load without a directly preceding no-op
    send(ld(1, 0)); send(32'h300); send(32'hDEAD);
    nop(); send(mi(6'h30, 23'd0)); send(32'h1); send(ld(1, 0)); send(32'h304); send(32'hBEEF);
    nop(); send(mi(6'h05, 23'd0)); send(ld(1, 0)); send(32'h308); send(32'hCAFE);
    nop(); send(ld(1, 0)); send(32'h30C); send(32'h0F0F);
    settle("R4");

    // R5: even length, one past the limit, exactly the limit
    nop(); send(ld(4, 0));
    for (int i = 0; i < 5; i++) send(32'h0000_0500 + 32'(i));
    nop(); send(ld(2 * MAXP + 1, 0));
    for (int i = 0; i < 2 * MAXP + 2; i++) send(32'h0000_0600 + 32'(4 * i));
    nop(); send(ld(2 * MAXP - 1, 0));
    for (int i = 0; i < MAXP; i++) begin send(32'h0001_0000 + 32'(4 * i)); send(32'(i)); end
    settle("R5");

    // R6: engine-relative addressing masks the offset
    bp = 1'b0;
    nop(); send(ld(3, 1));
    send(32'hFFFF_1234); send(32'h6001); send(32'h0000_E3F8); send(32'h6002);
    settle("R6");

    // R7: misaligned pair in the middle, plain and relative
    nop(); send(ld(5, 0));
    send(32'h400); send(32'h71); send(32'h402); send(32'h72); send(32'h408); send(32'h73);
    nop(); send(ld(1, 1)); send(32'h0000_1001); send(32'h74);
    settle("R7");

    // R8: skipped payloads that look like commands
    bp = 1'b1;
    send({3'd3, 21'd0, 8'd3}); send(mi(6'h00, 23'd0)); send(ld(1, 0)); send(32'h500); send(32'h1);
    send({3'd2, 21'd0, 8'd0}); send(mi(6'h0A, 23'd0));
    send(mi(6'h26, 23'd1)); send({3'd5, 29'd0}); send(ld(1, 0));
    nop(); send(ld(1, 0)); send(32'h504); send(32'h8008);
    settle("R8");

    // R1: unknown clients, then normal traffic resumes
    send({3'd5, 29'd0}); send({3'd1, 29'h22}); send({3'd7, 29'd1});
    nop(); send(ld(1, 0)); send(32'h600); send(32'h9009);
    settle("R1");

    // R2: end of batch, then normal traffic resumes
    bp = 1'b0;
    send(mi(6'h0A, 23'd0)); nop(); nop(); send(ld(1, 0)); send(32'h700); send(32'hA00A);
    settle("R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule